// File: doc/BRIEF.md
# Two-Frame Elastic Store with Conditional Recenter

This block decouples a framed byte stream of 32 timeslots per frame between a line-side write clock and a system-side read clock. It holds two frames (64 bytes) in a circular buffer. The line side writes one byte on each enabled write-clock edge. The system side reads one byte on each enabled read-clock edge, and the byte appears on a registered output. The write pointer crosses into the read domain as Gray code through a two-flop synchroniser. All decisions about the read pointer are made in the read domain, against that synchronised copy.

When the read side catches the writer, or the writer laps the reader, the read pointer jumps by one frame and a slip pulse reports the direction. Software can also request a recenter. The request is synchronised into the read domain and acts only on its rising edge. If the writer is less than half a frame (16 bytes) ahead of the reader, the read pointer is reloaded 16 bytes behind the writer and a "done" pulse is given. Otherwise the pointers stay as they are and a "skipped" pulse is given. The request is meant to be raised only after the read clock is running and stable.

Top module: `elasticStore`

## Requirements
- R1: After asynchronous reset, `rdData` is 0 and all four status pulses are low. The write pointer is 0 and the read pointer is 48, so the reader starts 16 bytes behind the writer.
- R2: A read request that is not on an align cycle and not a slip returns, after the next read-clock edge, the byte at the read pointer, and the pointer then advances by one (modulo 64). `rdData` holds its value when no read is made.
- R3: The separation is (synchronised write pointer − read pointer) mod 64. A read made at separation 0 raises `slipUnder` for one cycle and returns the byte at (read pointer − 32) mod 64. The read pointer then becomes that address + 1.
- R4: A read made at separation 63 raises `slipOver` for one cycle and returns the byte at (read pointer + 32) mod 64. The read pointer then becomes that address + 1.
- R5: On an align edge with separation below 16, the read pointer is loaded with (synchronised write pointer − 16) mod 64 and `alignDone` pulses for one cycle.
- R6: On an align edge with separation 16 or more, the read pointer is unchanged and `alignSkip` pulses for one cycle. Separation 16 is a skip and 15 is a recenter.
- R7: Only a 0-to-1 transition of `alignReq` acts. A level held high gives exactly one align event. A further event needs the input to go low and then high again.
- R8: A read request in the cycle where an align edge is acted on has no effect. The pointer does not advance for it and `rdData` holds. An align pulse and a slip pulse never occur together.
- R9: An align edge is acted on at the third rising read-clock edge at which `alignReq` is sampled high. The status pulse is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Line-side write clock |
| rdClk | input | 1 | System-side read clock |
| rstN | input | 1 | Asynchronous reset, active low, both domains |
| wrEn | input | 1 | Write one byte on this write-clock edge |
| wrData | input | 8 | Byte to write |
| rdEn | input | 1 | Read one byte on this read-clock edge |
| alignReq | input | 1 | Recenter request, acts on its rising edge (asynchronous) |
| rdData | output | 8 | Last byte read (registered) |
| slipUnder | output | 1 | One-cycle pulse: reader caught the writer, jumped one frame back |
| slipOver | output | 1 | One-cycle pulse: writer lapped the reader, jumped one frame forward |
| alignDone | output | 1 | One-cycle pulse: recenter carried out |
| alignSkip | output | 1 | One-cycle pulse: recenter request found separation at or above half a frame |

## Verification
The hardest situations to reach from the ports are an align edge arriving at an exact separation of 15 or 16, and a read arriving at an exact separation of 0 or 63. Both depend on the synchroniser lag between a write and its visibility in the read domain. The bench keeps its own model of buffer contents, both pointers and the three-edge lag. It steers the separation to a target with write-only or read-only bursts followed by idle cycles that let the synchroniser settle, and only then issues the align edge or the slipping read. A held-high request and an align edge that lands during a continuous read burst exercise the edge rule and the rule that a read on an align cycle is dropped.

// File: rtl/esPkg.sv
package esPkg;
  // Strobes from read-side control to the datapath / status registers.
  typedef struct packed {
    logic readStb;   // capture a byte into rdData
    logic underStb;  // reader caught the writer
    logic overStb;   // writer lapped the reader
    logic doneStb;   // recenter carried out
    logic skipStb;   // recenter request found enough separation
  } rdStrobes_t;
endpackage

// File: rtl/esDatapath.sv
module esDatapath
  import esPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int AW     = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  rdStrobes_t        ctl,
  input  logic [AW-1:0]     rdAddr,
  output logic [AW-1:0]     wrPtrSync,
  output logic [DATA_W-1:0] rdData
);

  function automatic logic [AW-1:0] toGray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW-1:0] fromGray(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, wrPtrInc, wrGray;
  logic [AW-1:0]     syncQ1, syncQ2;

  assign wrPtrInc = wrPtr + 1'b1;

  // Write domain: pointer plus registered Gray copy of the same pointer.
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (wrEn) begin
      wrPtr  <= wrPtrInc;
      wrGray <= toGray(wrPtrInc);
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  // Read domain: two-flop synchroniser on the Gray pointer.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= '0;
      syncQ2 <= '0;
    end else begin
      syncQ1 <= wrGray;
      syncQ2 <= syncQ1;
    end
  end

  assign wrPtrSync = fromGray(syncQ2);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.readStb) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/esControl.sv
module esControl
  import esPkg::*;
#(
  parameter int AW          = 6,
  parameter int FRAME_BYTES = 32,
  parameter int HALF        = 16
) (
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic          alignReq,
  input  logic [AW-1:0] wrPtrSync,
  output rdStrobes_t    stb,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] rdPtrQ,
  output logic          slipUnder,
  output logic          slipOver,
  output logic          alignDone,
  output logic          alignSkip
);

  localparam logic [AW-1:0] FRAME_STEP = AW'(FRAME_BYTES);
  localparam logic [AW-1:0] HALF_STEP  = AW'(HALF);
  localparam logic [AW-1:0] START_PTR  = AW'((1 << AW) - HALF);

  logic          reqS1, reqS2, reqPrev, alignRise;
  logic [AW-1:0] sep, rdPtrNext;

  assign alignRise = reqS2 & ~reqPrev;
  assign sep       = wrPtrSync - rdPtrQ;

  // Align takes priority over a read in the same cycle.
  always_comb begin
    stb       = '0;
    rdAddr    = rdPtrQ;
    rdPtrNext = rdPtrQ;
    if (alignRise) begin
      if (sep < HALF_STEP) begin
        stb.doneStb = 1'b1;
        rdPtrNext   = wrPtrSync - HALF_STEP;
      end else begin
        stb.skipStb = 1'b1;
      end
    end else if (rdEn) begin
      stb.readStb = 1'b1;
      if (sep == '0) begin
        stb.underStb = 1'b1;
        rdAddr       = rdPtrQ - FRAME_STEP;
      end else if (sep == '1) begin
        stb.overStb = 1'b1;
        rdAddr      = rdPtrQ + FRAME_STEP;
      end
      rdPtrNext = rdAddr + 1'b1;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      reqS1     <= 1'b0;
      reqS2     <= 1'b0;
      reqPrev   <= 1'b0;
      rdPtrQ    <= START_PTR;
      slipUnder <= 1'b0;
      slipOver  <= 1'b0;
      alignDone <= 1'b0;
      alignSkip <= 1'b0;
    end else begin
      reqS1     <= alignReq;
      reqS2     <= reqS1;
      reqPrev   <= reqS2;
      rdPtrQ    <= rdPtrNext;
      slipUnder <= stb.underStb;
      slipOver  <= stb.overStb;
      alignDone <= stb.doneStb;
      alignSkip <= stb.skipStb;
    end
  end

endmodule

// File: rtl/elasticStore.sv
module elasticStore
  import esPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 32,  // power of two
  parameter int FRAMES      = 2    // power of two
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              alignReq,
  output logic [DATA_W-1:0] rdData,
  output logic              slipUnder,
  output logic              slipOver,
  output logic              alignDone,
  output logic              alignSkip
);

  localparam int DEPTH = FRAME_BYTES * FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = FRAME_BYTES / 2;

  rdStrobes_t    stb;
  logic [AW-1:0] rdAddr, rdPtrQ, wrPtrSync;

  esDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) uDp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData),
    .ctl(stb), .rdAddr(rdAddr),
    .wrPtrSync(wrPtrSync), .rdData(rdData)
  );

  esControl #(.AW(AW), .FRAME_BYTES(FRAME_BYTES), .HALF(HALF)) uCtl (
    .rdClk(rdClk), .rstN(rstN), .rdEn(rdEn), .alignReq(alignReq),
    .wrPtrSync(wrPtrSync), .stb(stb), .rdAddr(rdAddr), .rdPtrQ(rdPtrQ),
    .slipUnder(slipUnder), .slipOver(slipOver),
    .alignDone(alignDone), .alignSkip(alignSkip)
  );

endmodule

// File: rtl/esChecker.sv
module esChecker #(
  parameter int DATA_W = 8,
  parameter int AW     = 6,
  parameter int HALF   = 16
) (
  input logic              rdClk,
  input logic              rstN,
  input logic [DATA_W-1:0] rdData,
  input logic              slipUnder,
  input logic              slipOver,
  input logic              alignDone,
  input logic              alignSkip,
  input logic [AW-1:0]     rdPtr,
  input logic [AW-1:0]     wrPtrSync
);

  localparam logic [AW-1:0] HALF_V = AW'(HALF);

  logic [AW-1:0] sepC;
  assign sepC = wrPtrSync - rdPtr;

  assert_under_at_zero_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    slipUnder |-> $past(sepC) == '0);

  assert_over_at_full_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    slipOver |-> $past(sepC) == '1);

  assert_recenter_target_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    alignDone |-> (rdPtr == $past(wrPtrSync) - HALF_V) && ($past(sepC) < HALF_V));

  assert_skip_keeps_ptr_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    alignSkip |-> (rdPtr == $past(rdPtr)) && ($past(sepC) >= HALF_V));

  assert_single_align_event_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    (alignDone || alignSkip) |=> !(alignDone || alignSkip));

  assert_exclusive_status_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    $onehot0({slipUnder, slipOver, alignDone, alignSkip}));

  assert_align_holds_data_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    (alignDone || alignSkip) |-> $stable(rdData));

endmodule

bind elasticStore esChecker #(.DATA_W(DATA_W), .AW(AW), .HALF(HALF)) uChk (
  .rdClk(rdClk), .rstN(rstN), .rdData(rdData),
  .slipUnder(slipUnder), .slipOver(slipOver),
  .alignDone(alignDone), .alignSkip(alignSkip),
  .rdPtr(rdPtrQ), .wrPtrSync(wrPtrSync)
);

// File: tb/test_elasticStore.sv
`timescale 1ns/1ps
module test_elasticStore;

  logic       clk = 1'b0;
  logic       rstN, wrEn, rdEn, alignReq;
  logic [7:0] wrData, rdData;
  logic       slipUnder, slipOver, alignDone, alignSkip;

  always #2.5 clk = ~clk;

  elasticStore i_elasticStore (
    .wrClk(clk), .rdClk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .alignReq(alignReq),
    .rdData(rdData), .slipUnder(slipUnder), .slipOver(slipOver),
    .alignDone(alignDone), .alignSkip(alignSkip)
  );

  typedef struct {
    logic [7:0] d;
    logic su, so, ad, as;
    string req;
  } exp_t;

  exp_t  q[$];
  int    nChk = 0, nFail = 0;
  string curReq = "R1";
  bit    finished = 0;

  // Reference model state
  logic [7:0] mMem [64];
  int   mWr = 0, mRd = 48;
  int   wA1 = 0, wA2 = 0, wA3 = 0;   // write pointer after edges e-1, e-2, e-3
  bit   rq1 = 0, rq2 = 0, rq3 = 0;   // alignReq sampled at edges e-1, e-2, e-3
  logic [7:0] lastData = 8'h00;
  logic [7:0] wrCnt = 8'h00;

  function automatic int sepNow();
    return (mWr - mRd) & 63;
  endfunction

  task automatic step(input bit we, input bit re, input bit ar);
    exp_t e;
    int   vis, sep, adr;
    bit   rise;
    @(negedge clk);
    wrEn = we; wrData = wrCnt; rdEn = re; alignReq = ar;
    e.su = 0; e.so = 0; e.ad = 0; e.as = 0; e.req = curReq;
    vis  = wA3;
    rise = rq2 && !rq3;
    sep  = (vis - mRd) & 63;
    if (rise) begin
      if (sep < 16) begin mRd = (vis - 16) & 63; e.ad = 1; end
      else e.as = 1;
    end else if (re) begin
      adr = mRd;
      if (sep == 0)       begin adr = (mRd - 32) & 63; e.su = 1; end
      else if (sep == 63) begin adr = (mRd + 32) & 63; e.so = 1; end
      lastData = mMem[adr];
      mRd = (adr + 1) & 63;
    end
    e.d = lastData;
    if (we) begin
      mMem[mWr] = wrCnt;
      mWr = (mWr + 1) & 63;
      wrCnt = wrCnt + 8'd1;
    end
    wA3 = wA2; wA2 = wA1; wA1 = mWr;
    rq3 = rq2; rq2 = rq1; rq1 = ar;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic setSep(input int target);
    idle(3);
    while (sepNow() > target) step(0, 1, 0);
    while (sepNow() < target) step(1, 0, 0);
    idle(3);
  endtask

  // Monitor: compare design outputs against queued expectations.
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      nChk++;
      if (rdData !== e.d || slipUnder !== e.su || slipOver !== e.so ||
          alignDone !== e.ad || alignSkip !== e.as) begin
        nFail++;
        $display("FAIL %s: got data=%h su=%b so=%b done=%b skip=%b, expected data=%h su=%b so=%b done=%b skip=%b",
                 e.req, rdData, slipUnder, slipOver, alignDone, alignSkip,
                 e.d, e.su, e.so, e.ad, e.as);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; rdEn = 0; alignReq = 0; wrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state at the ports
    nChk++;
    if (rdData !== 8'h00 || slipUnder || slipOver || alignDone || alignSkip) begin
      nFail++;
      $display("FAIL R1: got data=%h status=%b%b%b%b, expected 00 0000",
               rdData, slipUnder, slipOver, alignDone, alignSkip);
    end

    // R1 R2: prefill whole buffer, then stream; reader starts 16 behind
    curReq = "R1 R2";
    for (int i = 0; i < 64; i++) step(1, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 1, 0);
    curReq = "R2";
    for (int i = 0; i < 10; i++) step(i[0], !i[1], 0);

    // R3: reader catches writer
    curReq = "R3";
    idle(3);
    while (sepNow() != 0) step(0, 1, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    idle(2);

    // R4: writer laps reader
    curReq = "R4";
    idle(3);
    while (sepNow() != 63) step(1, 0, 0);
    idle(3);
    step(0, 1, 0);
    step(0, 1, 0);
    idle(2);

    // R6: separation exactly 16 -> skip, pointer kept
    curReq = "R6";
    setSep(16);
    step(0, 0, 1);
    idle(4);
    for (int i = 0; i < 3; i++) step(0, 1, 0);

    // R5 R9: separation 15 -> recenter on third edge after request
    curReq = "R5 R9";
    setSep(15);
    step(0, 0, 1);
    idle(4);
    for (int i = 0; i < 4; i++) step(1, 1, 0);

    // R5: deep recenter from separation 3
    curReq = "R5";
    setSep(3);
    step(0, 0, 1);
    idle(4);
    for (int i = 0; i < 5; i++) step(0, 1, 0);

    // R7: held level gives one event; re-arm after low
    curReq = "R7";
    setSep(5);
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    idle(3);
    setSep(7);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    idle(4);
    for (int i = 0; i < 3; i++) step(0, 1, 0);

    // R8: read requested on the align cycle is dropped
    curReq = "R8";
    setSep(30);
    step(0, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 1, 0);
    setSep(4);
    step(1, 1, 1);
    for (int i = 0; i < 8; i++) step(1, 1, 0);
    idle(3);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule